// File: doc/BRIEF.md
# Host-Bus to Video-Memory Block Transfer Engine

This engine moves a programmed run of 16-bit words from the host bus into one of three video memories: the pattern/name memory (VRAM), the colour memory (CRAM) or the vertical-scroll memory (VSRAM). Software loads a word-granular source address and a word count through a small byte-wide configuration port. A command decoder then pulses `start` with the destination memory, the destination byte address and the per-word address step. The engine pulls words from the host bus through a valid/ready read master and pushes each one into the chosen memory through a write port.

Three properties shape how the engine is used. A count of zero means the largest possible transfer. The source address advances only in its low half, so it wraps inside a 128 KB window. The source and count registers stay live after the run ends, which lets software chain a second transfer by reloading only the low count byte. The destination pointer is also kept and shown on `dst_next`, so a plain data-port write that follows the transfer lands right after the block.

Back-pressure on the read side: `rd_valid` and `rd_addr` hold steady until `rd_ready` is seen high at a clock edge. `rd_data` must be valid in the same cycle as `rd_ready`. The write port has no back-pressure: each `wr_valid` cycle is exactly one write.

Top module: `vmem_dma`

## Requirements
- R1: `cfg_sel` selects the register for a configuration write: 0 writes count bits 7:0, 1 writes count bits 15:8, 2 writes source word bits 7:0, 3 writes source word bits 15:8, 4 writes the fixed window bits (7 bits). `rd_addr` is the byte address {window, source word, 1'b0}, and `rd_valid` is high while a transfer is reading.
- R2: A count of 0 transfers 65536 words. Any other count N transfers exactly N words.
- R3: Each accepted read advances only the low 16-bit source word, wrapping from 0xFFFF to 0x0000. The window bits never change during a transfer.
- R4: After a transfer, the source register holds the word after the last one read and the count is 0. Reloading only count bits 7:0 and starting again continues from that source word.
- R5: The destination pointer loads `start_addr` and advances by `start_inc` (modulo 2^16) after each word. After the run, `dst_next` equals the start address plus N times the step.
- R6: `start_tgt` encodes the target as 0 = VRAM, 1 = CRAM, 2 = VSRAM. For VRAM, `wr_addr` is the full pointer. For CRAM and VSRAM, `wr_addr` is the pointer AND 0x7E: bit 0 is dropped and the address wraps in 0x80 bytes.
- R7: `wr_data` is the word read. It is ANDed with 0x0EEE for CRAM and with 0x03FF for VSRAM. VRAM receives the word unchanged.
- R8: While `rd_ready` is low, `rd_valid` and `rd_addr` are held. Every accepted word gives exactly one `wr_valid` cycle, in the very next cycle, with no word lost or repeated.
- R9: `busy` rises in the cycle after an accepted `start` and falls in the cycle after the last write. While `busy` is high, `start` and configuration writes are ignored. A `start` with target code 3 is ignored.
- R10: After reset, `busy`, `rd_valid` and `wr_valid` are 0, and `rd_addr` and `dst_next` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration byte |
| start | input | 1 | Start pulse from the command decoder |
| start_tgt | input | 2 | Destination memory code |
| start_addr | input | 16 | Destination start byte address |
| start_inc | input | 8 | Destination step per word |
| busy | output | 1 | Transfer in progress |
| dst_next | output | 16 | Current destination pointer |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 24 | Read byte address |
| rd_ready | input | 1 | Read accepted; data present |
| rd_data | input | 16 | Read word |
| wr_valid | output | 1 | Video memory write strobe |
| wr_tgt | output | 2 | Memory being written |
| wr_addr | output | 16 | Write byte address |
| wr_data | output | 16 | Write word, masked per target |

## Verification
The hardest situations to reach are two. The first is the full 65536-word run started from a count of 0. The second is a source that crosses 0xFFFF while the window bits must stay put, and it matters most when a stall sits right at the crossing. The stimulus does both directly. It starts one run with a zero count and lets every word stream through. It also sweeps short runs that begin just below 0xFFFF, under three ready patterns: always ready, alternating, and pseudo-random. A further run is chained off a finished one, and `start` and configuration writes are injected mid-run, so that ignored commands show up as wrong addresses or counts at the ports.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'd0,
    TGT_CRAM  = 2'd1,
    TGT_VSRAM = 2'd2,
    TGT_NONE  = 2'd3
  } vtgt_e;

  typedef enum logic [2:0] {
    RSEL_LEN_LO  = 3'd0,
    RSEL_LEN_HI  = 3'd1,
    RSEL_SRC_LO  = 3'd2,
    RSEL_SRC_MID = 3'd3,
    RSEL_SRC_WIN = 3'd4
  } rsel_e;

  localparam logic [DATA_W-1:0] CRAM_KEEP  = 16'h0EEE;
  localparam logic [DATA_W-1:0] VSRAM_KEEP = 16'h03FF;
endpackage

// File: rtl/vdma_src_regs.sv
// Count and source registers; they double as the live transfer counters.
// LEN_W and SRC_LO_W must lie in 9..16, SRC_HI_W in 1..8 (byte-wide config port).
module vdma_src_regs
  import vdma_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int SRC_LO_W = 16,
  parameter int SRC_HI_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [7:0]          cfg_wdata,
  input  logic                locked,
  input  logic                step,
  output logic [LEN_W-1:0]    len_q,
  output logic [SRC_LO_W-1:0] src_lo_q,
  output logic [SRC_HI_W-1:0] src_hi_q,
  output logic                last_word
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  assign last_word = (len_q == LEN_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q    <= '0;
      src_lo_q <= '0;
      src_hi_q <= '0;
    end else if (step) begin
      len_q    <= len_q - LEN_ONE;
      src_lo_q <= src_lo_q + SRC_LO_W'(1);
    end else if (cfg_we && !locked) begin
      case (rsel_e'(cfg_sel))
        RSEL_LEN_LO:  len_q[7:0]             <= cfg_wdata;
        RSEL_LEN_HI:  len_q[LEN_W-1:8]       <= cfg_wdata[LEN_W-9:0];
        RSEL_SRC_LO:  src_lo_q[7:0]          <= cfg_wdata;
        RSEL_SRC_MID: src_lo_q[SRC_LO_W-1:8] <= cfg_wdata[SRC_LO_W-9:0];
        RSEL_SRC_WIN: src_hi_q               <= cfg_wdata[SRC_HI_W-1:0];
        default: ;
      endcase
    end
  end

  // R2: each moved word takes one off the count
  assert_len_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> len_q == $past(len_q) - LEN_ONE);

  // R3: window bits frozen while stepping
  assert_window_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(src_hi_q));

  // R9: configuration writes have no effect while locked
  assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !step) |=> ($stable(len_q) && $stable(src_lo_q) && $stable(src_hi_q)));
endmodule

// File: rtl/vdma_seq.sv
// Run control: accepts start, issues reads, stops after the last word.
module vdma_seq
  import vdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] start_tgt,
  input  logic       last_word,
  input  logic       rd_ready,
  input  logic       wr_pending,
  output logic       run_q,
  output logic       accept,
  output logic       start_ok,
  output logic       busy,
  output vtgt_e      tgt_q
);
  assign busy     = run_q | wr_pending;
  assign accept   = run_q & rd_ready;
  assign start_ok = start & ~busy & (vtgt_e'(start_tgt) != TGT_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tgt_q <= TGT_VRAM;
    end else if (start_ok) begin
      run_q <= 1'b1;
      tgt_q <= vtgt_e'(start_tgt);
    end else if (accept && last_word) begin
      run_q <= 1'b0;
    end
  end

  // R9: reading stops right after the last word is taken
  assert_stop_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_word) |=> !run_q);

  // R8: a stall never ends the run
  assert_stall_keeps_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !rd_ready) |=> run_q);
endmodule

// File: rtl/vdma_wr_stage.sv
// Destination pointer, per-target address folding and data masking.
module vdma_wr_stage
  import vdma_pkg::*;
#(
  parameter int DST_W    = 16,
  parameter int INC_W    = 8,
  parameter int SMALL_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [DST_W-1:0]  start_addr,
  input  logic [INC_W-1:0]  start_inc,
  input  logic              accept,
  input  vtgt_e             tgt,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_valid,
  output vtgt_e             wr_tgt,
  output logic [DST_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DST_W-1:0]  dst_q
);
  logic [INC_W-1:0]  inc_q;
  logic [DST_W-1:0]  addr_fold;
  logic [DATA_W-1:0] data_mask;

  always_comb begin
    case (tgt)
      TGT_CRAM:  begin
        addr_fold = {{(DST_W-SMALL_AW){1'b0}}, dst_q[SMALL_AW-1:1], 1'b0};
        data_mask = rd_data & CRAM_KEEP;
      end
      TGT_VSRAM: begin
        addr_fold = {{(DST_W-SMALL_AW){1'b0}}, dst_q[SMALL_AW-1:1], 1'b0};
        data_mask = rd_data & VSRAM_KEEP;
      end
      default: begin
        addr_fold = dst_q;
        data_mask = rd_data;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_q    <= '0;
      inc_q    <= '0;
      wr_valid <= 1'b0;
      wr_tgt   <= TGT_VRAM;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= accept;
      if (start_ok) begin
        dst_q <= start_addr;
        inc_q <= start_inc;
      end else if (accept) begin
        dst_q   <= dst_q + DST_W'(inc_q);
        wr_tgt  <= tgt;
        wr_addr <= addr_fold;
        wr_data <= data_mask;
      end
    end
  end

  // R6: small memories see even addresses below 0x80
  assert_small_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt != TGT_VRAM) |-> (wr_addr[0] == 1'b0 && (wr_addr >> SMALL_AW) == '0));

  // R7: colour memory never receives bits outside its mask
  assert_cram_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_tgt == TGT_CRAM) |-> ((wr_data & ~CRAM_KEEP) == '0));

  // R8: each accepted read yields a write on the next cycle
  assert_write_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_valid);
endmodule

// File: rtl/vmem_dma.sv
module vmem_dma
  import vdma_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int SRC_LO_W = 16,
  parameter int SRC_HI_W = 7,
  parameter int DST_W    = 16,
  parameter int INC_W    = 8,
  parameter int SMALL_AW = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_sel,
  input  logic [7:0]                   cfg_wdata,
  input  logic                         start,
  input  logic [1:0]                   start_tgt,
  input  logic [DST_W-1:0]             start_addr,
  input  logic [INC_W-1:0]             start_inc,
  output logic                         busy,
  output logic [DST_W-1:0]             dst_next,
  output logic                         rd_valid,
  output logic [SRC_HI_W+SRC_LO_W:0]   rd_addr,
  input  logic                         rd_ready,
  input  logic [DATA_W-1:0]            rd_data,
  output logic                         wr_valid,
  output logic [1:0]                   wr_tgt,
  output logic [DST_W-1:0]             wr_addr,
  output logic [DATA_W-1:0]            wr_data
);
  logic [LEN_W-1:0]    len_q;
  logic [SRC_LO_W-1:0] src_lo_q;
  logic [SRC_HI_W-1:0] src_hi_q;
  logic                last_word, run_q, accept, start_ok, wr_v;
  vtgt_e               tgt_q, wr_tgt_e;

  vdma_src_regs #(.LEN_W(LEN_W), .SRC_LO_W(SRC_LO_W), .SRC_HI_W(SRC_HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .locked(busy), .step(accept), .len_q(len_q), .src_lo_q(src_lo_q),
    .src_hi_q(src_hi_q), .last_word(last_word));

  vdma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tgt(start_tgt),
    .last_word(last_word), .rd_ready(rd_ready), .wr_pending(wr_v),
    .run_q(run_q), .accept(accept), .start_ok(start_ok), .busy(busy), .tgt_q(tgt_q));

  vdma_wr_stage #(.DST_W(DST_W), .INC_W(INC_W), .SMALL_AW(SMALL_AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start_addr(start_addr),
    .start_inc(start_inc), .accept(accept), .tgt(tgt_q), .rd_data(rd_data),
    .wr_valid(wr_v), .wr_tgt(wr_tgt_e), .wr_addr(wr_addr), .wr_data(wr_data),
    .dst_q(dst_next));

  assign rd_valid = run_q;
  assign rd_addr  = {src_hi_q, src_lo_q, 1'b0};
  assign wr_valid = wr_v;
  assign wr_tgt   = wr_tgt_e;

  // R8: a stalled request holds its address
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R1: read addresses are always word aligned
  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_addr[0] == 1'b0);
endmodule

// File: tb/vmem_dma_tb.sv
module vmem_dma_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, start, busy, rd_valid, rd_ready, wr_valid;
  logic [2:0]  cfg_sel;
  logic [7:0]  cfg_wdata, start_inc;
  logic [1:0]  start_tgt, wr_tgt;
  logic [15:0] start_addr, dst_next, rd_data, wr_addr, wr_data;
  logic [23:0] rd_addr;

  vmem_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start(start), .start_tgt(start_tgt), .start_addr(start_addr), .start_inc(start_inc),
    .busy(busy), .dst_next(dst_next), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_tgt(wr_tgt),
    .wr_addr(wr_addr), .wr_data(wr_data));

  function automatic logic [15:0] host_word(input logic [23:0] a);
    return (a[16:1] * 16'h9E37) ^ {a[23:17], 9'h0A5};
  endfunction
  assign rd_data = host_word(rd_addr);

  int checks = 0, fails = 0, cycles = 0;
  int rmode = 0;
  logic [7:0] lfsr = 8'h5B;

  // model state
  logic [15:0] m_rd_lo, m_wr_lo, m_dst;
  logic [6:0]  m_hi;
  logic [7:0]  m_inc;
  logic [1:0]  m_tgt;
  int m_n, m_wr_cnt;
  bit mon_en = 0, prev_acc = 0, prev_stall = 0, prev_last = 0;
  logic [23:0] stall_addr;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    case (rmode)
      0: rd_ready = 1'b1;
      1: rd_ready = ~rd_ready;
      default: begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_ready = lfsr[0] | lfsr[2];
      end
    endcase
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) if (mon_en) begin
    logic [15:0] ea, ed;
    if (prev_stall)
      chk(rd_valid && rd_addr == stall_addr, "R8", "stalled address held", rd_addr, stall_addr);
    chk(wr_valid == prev_acc, "R8", "write one cycle after accept", wr_valid, prev_acc);
    if (prev_last) chk(!busy, "R9", "busy low after last write", busy, 0);
    prev_last = 0;
    if (wr_valid) begin
      ea = (m_tgt == 2'd0) ? m_dst : (m_dst & 16'h007E);
      ed = host_word({m_hi, m_wr_lo, 1'b0});
      if (m_tgt == 2'd1) ed = ed & 16'h0EEE;
      if (m_tgt == 2'd2) ed = ed & 16'h03FF;
      chk(wr_tgt == m_tgt, "R6", "write target", wr_tgt, m_tgt);
      chk(wr_addr == ea, "R6", "write address", wr_addr, ea);
      chk(wr_data == ed, "R7", "write data", wr_data, ed);
      m_wr_lo = m_wr_lo + 16'd1;
      m_dst   = m_dst + {8'h00, m_inc};
      m_wr_cnt++;
      prev_last = (m_wr_cnt == m_n);
    end
    if (rd_valid && rd_ready) begin
      chk(rd_addr == {m_hi, m_rd_lo, 1'b0}, "R1", "read address", rd_addr, {m_hi, m_rd_lo, 1'b0});
      m_rd_lo = m_rd_lo + 16'd1;
    end
    prev_acc   = rd_valid && rd_ready;
    prev_stall = rd_valid && !rd_ready;
    stall_addr = rd_addr;
  end

  task automatic cfg(input logic [2:0] sel, input logic [7:0] val);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_len(input logic [15:0] n);
    cfg(3'd0, n[7:0]); cfg(3'd1, n[15:8]);
    m_n = (n == 16'd0) ? 65536 : int'(n);
  endtask

  task automatic set_src(input logic [6:0] hi, input logic [15:0] lo);
    cfg(3'd2, lo[7:0]); cfg(3'd3, lo[15:8]); cfg(3'd4, {1'b0, hi});
    m_hi = hi; m_rd_lo = lo; m_wr_lo = lo;
  endtask

  task automatic launch(input logic [1:0] t, input logic [15:0] a, input logic [7:0] inc);
    m_tgt = t; m_dst = a; m_inc = inc; m_wr_cnt = 0;
    start = 1'b1; start_tgt = t; start_addr = a; start_inc = inc;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    chk(busy, "R9", "busy after start", busy, 1);
  endtask

  task automatic finish_run(input string req);
    logic [15:0] expd;
    int guard = 0;
    while (busy && guard < 70000) begin @(negedge clk); guard++; end
    chk(m_wr_cnt == m_n, req, "word count", m_wr_cnt, m_n);
    expd = m_dst;
    chk(dst_next == expd, "R5", "destination after run", dst_next, expd);
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; start = 0;
    start_tgt = 0; start_addr = 0; start_inc = 0; rd_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !rd_valid && !wr_valid, "R10", "idle flags", {busy, rd_valid, wr_valid}, 0);
    chk(rd_addr == 24'd0 && dst_next == 16'd0, "R10", "reset addresses", rd_addr, 0);
    @(posedge clk); #1;
    mon_en = 1;

    // sweep: targets x steps x lengths x ready patterns, source crossing 0xFFFF (R3)
    for (int rm = 0; rm < 3; rm++)
      for (int t = 0; t < 3; t++)
        for (int s = 0; s < 3; s++)
          for (int l = 0; l < 3; l++) begin
            logic [7:0] incs [3];
            logic [15:0] lens [3];
            incs = '{8'd1, 8'd2, 8'd3};
            lens = '{16'd1, 16'd2, 16'd5};
            rmode = rm;
            set_src(7'(7'h41 + t), 16'(16'hFFFD + s));
            set_len(lens[l]);
            launch(2'(t), 16'(16'h0075 + 16'(s * 16'h1111)), incs[s]);
            finish_run("R2");
          end

    // R3 window fixed across wrap with stalls, VSRAM odd pointer
    rmode = 2;
    set_src(7'h7F, 16'hFFFE); set_len(16'd6);
    launch(2'd2, 16'h007D, 8'd2);
    finish_run("R3");

    // R4 chaining: reload only count low byte
    rmode = 0;
    set_src(7'h12, 16'h0040); set_len(16'd3);
    launch(2'd0, 16'h0100, 8'd2);
    finish_run("R4");
    cfg(3'd0, 8'd2); m_n = 2;
    launch(2'd0, 16'h0104, 8'd2);
    finish_run("R4");

    // R9 start and config writes ignored while busy
    rmode = 1;
    set_src(7'h03, 16'h2000); set_len(16'd8);
    launch(2'd1, 16'h0010, 8'd4);
    start = 1'b1; start_tgt = 2'd2; start_addr = 16'h5555; start_inc = 8'd9;
    @(posedge clk); #1; start = 1'b0;
    cfg(3'd2, 8'hAA); cfg(3'd4, 8'h01); cfg(3'd0, 8'h40);
    finish_run("R9");

    // R9 target code 3 ignored
    start = 1'b1; start_tgt = 2'd3;
    @(posedge clk); #1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !rd_valid && !wr_valid, "R9", "target 3 ignored", busy, 0);
    @(posedge clk); #1;

    // R2 zero count moves 65536 words, pointer returns to start (R5)
    rmode = 0;
    set_src(7'h05, 16'h8000); set_len(16'd0);
    launch(2'd0, 16'h0200, 8'd2);
    finish_run("R2");

    mon_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule